// File: doc/BRIEF.md
# SPI Master Slave-Select and Interrupt Control Unit

This block holds the control-side state that sits beside an SPI master shift engine. It has two word-wide registers on a simple read/write port. The control register holds five interrupt enables and a force-select bit. The slave mask register holds one bit per active-low slave-select output.

The block ANDs the status flags reported by the shift engine with their enables and ORs the results into a single interrupt request. It drives each slave-select line low when that slave's mask bit is set and either a shift is in progress or the force bit is set. Holding the force bit lets software keep a slave selected across several transfers, so frames longer than one word can be built. Several mask bits may be set together to select several slaves at once.

The register port is a plain strobe interface with no back-pressure. A write is accepted on every cycle in which `wr_en_i` is high. A read is accepted on every cycle in which `rd_en_i` is high, and its data appears on the following cycle.

Top module: `spi_sel_ctl`

## Requirements
- R1: After reset the control register reads back as 0, so no interrupt is enabled and no forced selection is active.
- R2: After reset the slave mask reads back as 1, so only slave 0 is selected (ss_n_o[0] goes low when busy_i is high).
- R3: A write with addr_i=0 updates the control register on the next clock edge. Only bits 3, 4, 6, 7, 8 (enables) and 10 (force) are stored, and every other bit reads as 0.
- R4: A write with addr_i=1 stores wdata_i[NUM_SS-1:0] into the slave mask on the next clock edge. Mask bits above NUM_SS-1 read as 0.
- R5: When rd_en_i is high at a clock edge, rdata_o shows the register selected by addr_i as it stood before that edge, so a write in the same cycle is not yet visible. Otherwise rdata_o holds its value, and it is 0 after reset.
- R6: irq_o is high in the same cycle whenever, for some position p in {3 (receive overrun), 4 (transmit overrun), 6 (transmit ready), 7 (receive ready), 8 (any error)}, status_i[p] and control bit p are both 1.
- R7: Status bits at positions outside {3,4,6,7,8} never raise irq_o.
- R8: ss_n_o[i] = ~(mask[i] & (busy_i | force)), where force is control bit 10. With busy_i low and force clear, all outputs are high.
- R9: With the force bit set, the selected ss_n_o outputs are low even while busy_i is low.
- R10: Several mask bits set together assert all of the corresponding ss_n_o outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register select: 0 = control, 1 = slave mask |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid one cycle after the read strobe |
| status_i | input | DATA_W | Status flags from the shift engine |
| busy_i | input | 1 | High while a shift is in progress |
| ss_n_o | output | NUM_SS | Active-low slave-select outputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check the following on every cycle:
- register writes land with the stored-bit masking applied;
- read data follows a read strobe by exactly one cycle;
- all selects are released when the block is idle and not forced;
- no interrupt fires while every enable is clear.

Other behaviours can only be shown by the bench scenarios: the reset values, the gating of each individual enable, the rejection of status bits outside the enable positions, multi-slave selection, forced selection between transfers, and the ordering of a read and a write in the same cycle. A behavioural model compares rdata_o, irq_o and ss_n_o on every clock through directed and random traffic.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam int RX_OVF_POS  = 3;
  localparam int TX_OVF_POS  = 4;
  localparam int TX_RDY_POS  = 6;
  localparam int RX_RDY_POS  = 7;
  localparam int ANY_ERR_POS = 8;
  localparam int FORCE_POS   = 10;
  localparam int CTRL_MIN_W  = FORCE_POS + 1;

  // Positions where a status flag is gated by a same-position enable.
  localparam logic [31:0] IRQ_EN_BITS =
    (32'd1 << RX_OVF_POS) | (32'd1 << TX_OVF_POS) | (32'd1 << TX_RDY_POS) |
    (32'd1 << RX_RDY_POS) | (32'd1 << ANY_ERR_POS);

  // All control bits that hold state.
  localparam logic [31:0] CTRL_STORED_BITS = IRQ_EN_BITS | (32'd1 << FORCE_POS);

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sel_regfile.sv
module sel_regfile
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_SS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [NUM_SS-1:0] mask_q
);
  localparam logic [DATA_W-1:0] STORED = DATA_W'(CTRL_STORED_BITS);
  localparam logic [NUM_SS-1:0] MASK_RST = NUM_SS'(1);

  logic ctrl_we, mask_we;
  assign ctrl_we = wr_en_i && (reg_sel_e'(addr_i) == SEL_CTRL);
  assign mask_we = wr_en_i && (reg_sel_e'(addr_i) == SEL_MASK);

  // One flop per stored control bit; the rest are tied to zero.
  for (genvar b = 0; b < DATA_W; b++) begin : g_ctrl
    if (STORED[b]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q[b] <= 1'b0;
        else if (ctrl_we) ctrl_q[b] <= wdata_i[b];
      end
    end else begin : g_zero
      assign ctrl_q[b] = 1'b0;
    end
  end

  // Slave mask flops; slave 0 is selected out of reset.
  for (genvar s = 0; s < NUM_SS; s++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q[s] <= MASK_RST[s];
      else if (mask_we) mask_q[s] <= wdata_i[s];
    end
  end

  // R3: a control write lands one edge later, masked to the stored bits.
  a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en_i) && !$past(addr_i))
      |-> (ctrl_q == ($past(wdata_i) & STORED)));

  // R4: a mask write lands one edge later.
  a_r4_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en_i) && $past(addr_i))
      |-> (mask_q == $past(wdata_i[NUM_SS-1:0])));
endmodule

// File: rtl/sel_irq.sv
module sel_irq
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] ctrl_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] EN_POS = DATA_W'(IRQ_EN_BITS);

  logic [DATA_W-1:0] hits;
  assign hits  = status_i & ctrl_i & EN_POS;
  assign irq_o = |hits;

  // R6: with every enable clear, no interrupt is raised.
  a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_i & EN_POS) == '0) |-> !irq_o);
endmodule

// File: rtl/sel_ssdrv.sv
module sel_ssdrv #(
  parameter int NUM_SS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SS-1:0] mask_i,
  input  logic              busy_i,
  input  logic              force_i,
  output logic [NUM_SS-1:0] ss_n_o
);
  logic drive_en;
  assign drive_en = busy_i | force_i;

  for (genvar s = 0; s < NUM_SS; s++) begin : g_ss
    assign ss_n_o[s] = ~(mask_i[s] & drive_en);
  end

  // R8: when idle and not forced, every select is released.
  a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !force_i) |-> (&ss_n_o));
endmodule

// File: rtl/sel_rdport.sv
module sel_rdport
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_SS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic [NUM_SS-1:0] mask_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_CTRL: rd_mux = ctrl_i;
      SEL_MASK: rd_mux = DATA_W'(mask_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  // R5: read data is the pre-edge register contents, one cycle later.
  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_en_i)) |-> (rdata_o == $past(rd_mux)));
endmodule

// File: rtl/spi_sel_ctl.sv
module spi_sel_ctl
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_SS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] status_i,
  input  logic              busy_i,
  output logic [NUM_SS-1:0] ss_n_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [NUM_SS-1:0] mask_q;

  initial begin
    if (DATA_W < CTRL_MIN_W) $error("DATA_W too small for control bits");
    if (NUM_SS > DATA_W || NUM_SS < 1) $error("NUM_SS out of range");
  end

  sel_regfile #(.DATA_W(DATA_W), .NUM_SS(NUM_SS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ctrl_q(ctrl_q), .mask_q(mask_q)
  );

  sel_irq #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .ctrl_i(ctrl_q),
    .irq_o(irq_o)
  );

  sel_ssdrv #(.NUM_SS(NUM_SS)) u_ss (
    .clk(clk), .rst_n(rst_n), .mask_i(mask_q), .busy_i(busy_i),
    .force_i(ctrl_q[FORCE_POS]), .ss_n_o(ss_n_o)
  );

  sel_rdport #(.DATA_W(DATA_W), .NUM_SS(NUM_SS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .ctrl_i(ctrl_q), .mask_i(mask_q), .rdata_o(rdata_o)
  );
endmodule

// File: tb/test_spi_sel_ctl.sv
`timescale 1ns/1ps
module test_spi_sel_ctl;
  localparam int DATA_W = 32;
  localparam int NUM_SS = 8;
  localparam real CLK_PER = 20.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, busy = 1'b0;
  logic [DATA_W-1:0] wdata = '0, status = '0;
  logic [DATA_W-1:0] rdata;
  logic [NUM_SS-1:0] ss_n;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  spi_sel_ctl #(.DATA_W(DATA_W), .NUM_SS(NUM_SS)) i_spi_sel_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .status_i(status), .busy_i(busy),
    .ss_n_o(ss_n), .irq_o(irq)
  );

  // Behavioural model state.
  int en_pos[$] = '{3, 4, 6, 7, 8};
  int force_bit = 10;
  logic [31:0] m_ctrl, m_mask, m_rdata;

  function automatic logic [31:0] stored_bits();
    logic [31:0] v = 32'd1 << force_bit;
    foreach (en_pos[k]) v |= 32'd1 << en_pos[k];
    return v;
  endfunction

  function automatic logic exp_irq(logic [31:0] st, logic [31:0] c);
    foreach (en_pos[k]) if (st[en_pos[k]] && c[en_pos[k]]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [NUM_SS-1:0] exp_ss(logic [31:0] m, logic b, logic [31:0] c);
    logic [NUM_SS-1:0] v;
    for (int i = 0; i < NUM_SS; i++) v[i] = !(m[i] && (b || c[force_bit]));
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Model update at each edge, comparison 4 ns later.
  always @(posedge clk) begin
    logic s_we, s_re, s_a;
    logic [31:0] s_d;
    s_we = wr_en; s_re = rd_en; s_a = addr; s_d = wdata;
    if (!rst_n) begin
      m_ctrl = 0; m_mask = 1; m_rdata = 0;
    end else begin
      if (s_re) m_rdata = s_a ? m_mask : m_ctrl;
      if (s_we && !s_a) m_ctrl = s_d & stored_bits();
      if (s_we && s_a)  m_mask = s_d & ((32'd1 << NUM_SS) - 1);
      #4;
      check(rdata == m_rdata, "R5 rdata", rdata, m_rdata);
      check(irq == exp_irq(status, m_ctrl), "R6 irq", 32'(irq), 32'(exp_irq(status, m_ctrl)));
      check(ss_n == exp_ss(m_mask, busy, m_ctrl), "R8 ss_n", 32'(ss_n),
            32'(exp_ss(m_mask, busy, m_ctrl)));
    end
  end

  task automatic cyc(bit we, bit re, bit a, logic [31:0] d, logic [31:0] st, bit b);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d; status = st; busy = b;
    @(posedge clk);
    #4;
  endtask

  initial begin
    #(CLK_PER * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cyc(0, 1, 0, 0, 0, 0);
    check(rdata == 0, "R1 ctrl reset", rdata, 0);
    cyc(0, 1, 1, 0, 0, 0);
    check(rdata == 1, "R2 mask reset", rdata, 1);
    check(ss_n == 8'hFF, "R8 idle release", 32'(ss_n), 32'hFF);
    cyc(0, 0, 0, 0, 0, 1);
    check(ss_n == 8'hFE, "R2 slave0 on busy", 32'(ss_n), 32'hFE);

    cyc(1, 0, 0, 32'hFFFF_FFFF, 0, 0);
    check(ss_n == 8'hFE, "R9 force no busy", 32'(ss_n), 32'hFE);
    cyc(0, 1, 0, 0, 0, 0);
    check(rdata == 32'h5D8, "R3 stored bits", rdata, 32'h5D8);

    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 32'hFFFF_FF62, 0, 0);
    cyc(0, 1, 1, 0, 0, 1);
    check(rdata == 32'h62, "R4 mask width", rdata, 32'h62);
    check(ss_n == 8'h9D, "R10 multi select", 32'(ss_n), 32'h9D);
    cyc(0, 0, 0, 0, 0, 0);
    check(ss_n == 8'hFF, "R8 release", 32'(ss_n), 32'hFF);
    cyc(1, 0, 0, 32'h400, 0, 0);
    check(ss_n == 8'h9D, "R9 forced multi", 32'(ss_n), 32'h9D);
    cyc(1, 0, 0, 0, 0, 0);
    check(ss_n == 8'hFF, "R9 force cleared", 32'(ss_n), 32'hFF);

    cyc(0, 0, 0, 0, 32'hFFFF_FFFF, 0);
    check(irq == 0, "R6 no enables", 32'(irq), 0);
    cyc(1, 0, 0, 32'h1D8, 32'hFFFF_FE27, 0);
    check(irq == 0, "R7 unrelated status", 32'(irq), 0);
    foreach (en_pos[k]) begin
      cyc(0, 0, 0, 0, 32'd1 << en_pos[k], 0);
      check(irq == 1, "R6 single enable", 32'(irq), 1);
    end
    cyc(1, 0, 0, 32'h100, 32'h0000_0100, 0);
    check(irq == 1, "R6 any error", 32'(irq), 1);
    cyc(0, 0, 0, 0, 32'h0000_0008, 0);
    check(irq == 0, "R6 disabled flag", 32'(irq), 0);

    cyc(1, 0, 0, 32'h1D8, 0, 0);
    cyc(1, 1, 0, 32'h10, 0, 0);
    check(rdata == 32'h1D8, "R5 read before write", rdata, 32'h1D8);
    cyc(0, 1, 0, 0, 32'h10, 0);
    check(rdata == 32'h10, "R5 read after write", rdata, 32'h10);
    check(irq == 1, "R6 tx overrun", 32'(irq), 1);

    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 9));
      cyc(r < 2, r >= 7, $urandom_range(0, 1) == 1, $urandom, $urandom,
          $urandom_range(0, 1) == 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule